// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block holds the machine-mode trap state of a small processor core: the saved exception PC, the interrupt-enable, previous-enable and previous-privilege status bits, the trap cause, the trap base address and the current privilege level (machine or user). The pipeline hands it a trap request (an exception with a cause code, or an interrupt with an ID) or a return request. The block answers one cycle later with a fetch redirect address, and it updates the trap state in the same clock edge.

Exceptions redirect fetch to the trap base itself. Interrupts redirect to the base plus four times their ID. The highest ID is reserved for the non-maskable interrupt. When that interrupt is taken, a hidden one-deep backup captures the previous-privilege, previous-enable, exception-PC and cause state before normal entry overwrites them. The matching return puts that state back, so a handler that was interrupted by the non-maskable interrupt can still return correctly. After reset the block issues one boot redirect. Its address is the upper bits of the boot address with 0x80 as the low byte. The trap base starts at the boot address with its low byte cleared.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is low and after it is released, privilege is machine (2'b11), the enable bit and previous-enable bit are 0, previous privilege is machine (2'b11), the non-maskable flag is 0, and the trap base equals the boot address with bits 7:0 cleared.
- R2: In the first cycle after reset is released, the redirect valid output is 1 and the redirect address is boot address bits 31:8 followed by 8'h80. In the cycle after that, the valid output is 0.
- R3: An accepted trap stores the trap PC as the exception PC and copies the enable bit into the previous-enable bit. It clears the enable bit, records the current privilege as previous privilege, sets privilege to machine, and writes the cause as {interrupt flag in bit 31, zeros, 5-bit code in bits 4:0}.
- R4: An exception (interrupt flag 0) redirects fetch to the trap base, whatever its code (1, 2, 3, 5, 7, 8 and 11 are the defined ones).
- R5: An interrupt with ID n redirects fetch to trap base + 4*n. ID 31 is the non-maskable interrupt and lands at base + 0x7C.
- R6: An ordinary return redirects fetch to the exception PC, copies previous-enable into the enable bit and previous privilege into privilege, then sets previous-enable to 1 and previous privilege to user (2'b00).
- R7: A trap-base write stores write data bits 31:8 with bits 7:0 forced to zero. It takes effect from the next cycle.
- R8: Taking interrupt ID 31 saves the live previous-privilege, previous-enable, exception-PC and cause into the backup and sets the non-maskable flag.
- R9: While the non-maskable flag is set, interrupt requests (including ID 31) produce no redirect and leave all trap state unchanged.
- R10: A return while the non-maskable flag is set redirects to the live exception PC and copies previous-enable into enable and previous privilege into privilege. It then restores previous-privilege, previous-enable, exception PC and cause from the backup and clears the flag.
- R11: Each accepted trap or return gives exactly one redirect-valid cycle, one cycle after the request. A trap and a return requested together act as the trap alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| boot_addr_i | input | 32 | Boot address, low byte expected zero |
| trap_req_i | input | 1 | Trap entry request |
| trap_irq_i | input | 1 | 1: interrupt, 0: exception |
| trap_code_i | input | 5 | Interrupt ID or exception code |
| trap_pc_i | input | 32 | PC to save on entry |
| ret_req_i | input | 1 | Return-from-trap request |
| base_we_i | input | 1 | Trap-base write strobe |
| base_wdata_i | input | 32 | Trap-base write data |
| fetch_valid_o | output | 1 | Redirect valid |
| fetch_pc_o | output | 32 | Redirect address |
| priv_o | output | 2 | Current privilege (11 machine, 00 user) |
| ie_o | output | 1 | Interrupt-enable bit |
| pie_o | output | 1 | Previous-enable bit |
| ppriv_o | output | 2 | Previous privilege |
| epc_o | output | 32 | Saved exception PC |
| cause_o | output | 32 | Trap cause |
| tbase_o | output | 32 | Trap base |
| nmi_active_o | output | 1 | Non-maskable handler in progress |

## Verification
The assertions assume that every input is driven to a known value from the first clock edge. They also assume that a request lasts exactly one cycle, so each entry or return maps to a single clock edge. The bench drives all inputs to zero before reset and raises each request for one cycle from a task, with idle cycles between requests. Boot addresses and trap PCs are word aligned and the boot address has a zero low byte, as the design requires. The only unaligned value used is the trap-base write data, which exercises the masking of its low byte.

// File: rtl/trap_pkg.sv
// Package: shared types for the trap controller.
// Assumes privilege is encoded in two bits, machine = 2'b11, user = 2'b00.
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_M = 2'b11
    } priv_e;

    typedef struct packed {
        logic  ie;
        logic  pie;
        priv_e pp;
    } status_t;

endpackage

// File: rtl/trap_target.sv
// Module: trap_target
// Works out the redirect target and the cause word for a trap request.
// Assumes the trap base is aligned so that base + 4*ID causes no carry problems.
module trap_target #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic [XLEN-1:0]   tbase_i,
    input  logic              irq_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   target_o,
    output logic [XLEN-1:0]   cause_o
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    // Vector offset for interrupts, base alone for exceptions.
    always_comb begin
        if (irq_i) begin
            target_o = tbase_i + (XLEN'(code_i) << 2);
        end else begin
            target_o = tbase_i;
        end
    end

    // Cause word: interrupt flag on top, code at the bottom.
    always_comb begin
        cause_o = {irq_i, {PAD_W{1'b0}}, code_i};
    end

endmodule

// File: rtl/trap_nmi_stack.sv
// Module: trap_nmi_stack
// One-deep hidden backup of the trap state, filled on non-maskable entry.
// Assumes push and pop are never requested in the same cycle.
module trap_nmi_stack #(
    parameter int XLEN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    input  trap_pkg::priv_e   pp_i,
    input  logic              pie_i,
    input  logic [XLEN-1:0]   epc_i,
    input  logic [XLEN-1:0]   cause_i,
    output trap_pkg::priv_e   pp_o,
    output logic              pie_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic              active_o
);
    import trap_pkg::*;

    priv_e            pp_q;
    logic             pie_q;
    logic [XLEN-1:0]  epc_q;
    logic [XLEN-1:0]  cause_q;
    logic             active_q;

    // Capture live state on push.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pp_q    <= PRIV_M;
            pie_q   <= 1'b0;
            epc_q   <= '0;
            cause_q <= '0;
        end else if (push_i) begin
            pp_q    <= pp_i;
            pie_q   <= pie_i;
            epc_q   <= epc_i;
            cause_q <= cause_i;
        end
    end

    // Track whether a non-maskable handler is running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q <= 1'b0;
        end else if (push_i) begin
            active_q <= 1'b1;
        end else if (pop_i) begin
            active_q <= 1'b0;
        end
    end

    assign pp_o     = pp_q;
    assign pie_o    = pie_q;
    assign epc_o    = epc_q;
    assign cause_o  = cause_q;
    assign active_o = active_q;

endmodule

// File: rtl/trap_csr_state.sv
// Module: trap_csr_state
// Holds exception PC, cause, status bits, privilege and trap base.
// Assumes entry and return are already prioritised (never both set).
module trap_csr_state #(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [XLEN-1:0]   boot_addr_i,
    input  logic              entry_i,
    input  logic              ret_i,
    input  logic              restore_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   cause_i,
    input  logic              base_we_i,
    input  logic [XLEN-1:0]   base_wdata_i,
    input  trap_pkg::priv_e   bk_pp_i,
    input  logic              bk_pie_i,
    input  logic [XLEN-1:0]   bk_epc_i,
    input  logic [XLEN-1:0]   bk_cause_i,
    output trap_pkg::status_t status_o,
    output trap_pkg::priv_e   priv_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   tbase_o
);
    import trap_pkg::*;

    localparam int HI_W = XLEN - ALIGN_BITS;

    status_t          status_q;
    priv_e            priv_q;
    logic [XLEN-1:0]  epc_q;
    logic [XLEN-1:0]  cause_q;
    logic [XLEN-1:0]  tbase_q;

    // Trap base: boot value at reset, aligned software write afterwards.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tbase_q <= {boot_addr_i[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else if (base_we_i) begin
            tbase_q <= {base_wdata_i[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    // Status, privilege, exception PC and cause on entry and return.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            status_q <= '{ie: 1'b0, pie: 1'b0, pp: PRIV_M};
            priv_q   <= PRIV_M;
            epc_q    <= '0;
            cause_q  <= '0;
        end else if (entry_i) begin
            epc_q        <= pc_i;
            cause_q      <= cause_i;
            status_q.ie  <= 1'b0;
            status_q.pie <= status_q.ie;
            status_q.pp  <= priv_q;
            priv_q       <= PRIV_M;
        end else if (ret_i) begin
            priv_q      <= status_q.pp;
            status_q.ie <= status_q.pie;
            if (restore_i) begin
                status_q.pie <= bk_pie_i;
                status_q.pp  <= bk_pp_i;
                epc_q        <= bk_epc_i;
                cause_q      <= bk_cause_i;
            end else begin
                status_q.pie <= 1'b1;
                status_q.pp  <= PRIV_U;
            end
        end
    end

    assign status_o = status_q;
    assign priv_o   = priv_q;
    assign epc_o    = epc_q;
    assign cause_o  = cause_q;
    assign tbase_o  = tbase_q;

    logic unused_hi;
    assign unused_hi = |HI_W;

endmodule

// File: rtl/trap_ctrl.sv
// Module: trap_ctrl (top)
// Machine trap entry/return controller with a hidden non-maskable backup.
// Assumes requests are single-cycle pulses and the boot address low byte is zero.
module trap_ctrl #(
    parameter int XLEN         = 32,
    parameter int CODE_W       = 5,
    parameter int ALIGN_BITS   = 8,
    parameter int BOOT_OFFSET  = 'h80,
    parameter bit NMI_STACK_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [XLEN-1:0]   boot_addr_i,
    input  logic              trap_req_i,
    input  logic              trap_irq_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic              ret_req_i,
    input  logic              base_we_i,
    input  logic [XLEN-1:0]   base_wdata_i,
    output logic              fetch_valid_o,
    output logic [XLEN-1:0]   fetch_pc_o,
    output logic [1:0]        priv_o,
    output logic              ie_o,
    output logic              pie_o,
    output logic [1:0]        ppriv_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   tbase_o,
    output logic              nmi_active_o
);
    import trap_pkg::*;

    localparam logic [CODE_W-1:0]     NMI_ID   = {CODE_W{1'b1}};
    localparam logic [ALIGN_BITS-1:0] BOOT_LOW = ALIGN_BITS'(BOOT_OFFSET);

    logic             take_trap, take_nmi, take_ret, nmi_ret, nmi_active;
    logic [XLEN-1:0]  target, new_cause, next_pc;
    status_t          status;
    priv_e            priv;
    logic [XLEN-1:0]  epc, cause, tbase;
    priv_e            bk_pp;
    logic             bk_pie;
    logic [XLEN-1:0]  bk_epc, bk_cause;
    logic             fetch_valid_q;
    logic [XLEN-1:0]  fetch_pc_q;

    // Request arbitration: interrupts blocked in the non-maskable handler, trap beats return.
    always_comb begin
        take_trap = trap_req_i && !(trap_irq_i && nmi_active);
        take_nmi  = take_trap && trap_irq_i && (trap_code_i == NMI_ID);
        take_ret  = ret_req_i && !take_trap;
        nmi_ret   = take_ret && nmi_active;
        next_pc   = take_trap ? target : epc;
    end

    trap_target #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) i_target (
        .tbase_i  (tbase),
        .irq_i    (trap_irq_i),
        .code_i   (trap_code_i),
        .target_o (target),
        .cause_o  (new_cause)
    );

    trap_csr_state #(
        .XLEN       (XLEN),
        .ALIGN_BITS (ALIGN_BITS)
    ) i_state (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .boot_addr_i  (boot_addr_i),
        .entry_i      (take_trap),
        .ret_i        (take_ret),
        .restore_i    (nmi_ret),
        .pc_i         (trap_pc_i),
        .cause_i      (new_cause),
        .base_we_i    (base_we_i),
        .base_wdata_i (base_wdata_i),
        .bk_pp_i      (bk_pp),
        .bk_pie_i     (bk_pie),
        .bk_epc_i     (bk_epc),
        .bk_cause_i   (bk_cause),
        .status_o     (status),
        .priv_o       (priv),
        .epc_o        (epc),
        .cause_o      (cause),
        .tbase_o      (tbase)
    );

    if (NMI_STACK_EN) begin : g_stack
        trap_nmi_stack #(
            .XLEN (XLEN)
        ) i_stack (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .push_i   (take_nmi),
            .pop_i    (nmi_ret),
            .pp_i     (status.pp),
            .pie_i    (status.pie),
            .epc_i    (epc),
            .cause_i  (cause),
            .pp_o     (bk_pp),
            .pie_o    (bk_pie),
            .epc_o    (bk_epc),
            .cause_o  (bk_cause),
            .active_o (nmi_active)
        );
    end else begin : g_no_stack
        assign bk_pp      = PRIV_U;
        assign bk_pie     = 1'b0;
        assign bk_epc     = '0;
        assign bk_cause   = '0;
        assign nmi_active = 1'b0;
    end

    // Fetch redirect register: boot address at reset, then one pulse per accepted request.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fetch_valid_q <= 1'b1;
            fetch_pc_q    <= {boot_addr_i[XLEN-1:ALIGN_BITS], BOOT_LOW};
        end else begin
            fetch_valid_q <= take_trap || take_ret;
            if (take_trap || take_ret) begin
                fetch_pc_q <= next_pc;
            end
        end
    end

    assign fetch_valid_o = fetch_valid_q;
    assign fetch_pc_o    = fetch_pc_q;
    assign priv_o        = priv;
    assign ie_o          = status.ie;
    assign pie_o         = status.pie;
    assign ppriv_o       = status.pp;
    assign epc_o         = epc;
    assign cause_o       = cause;
    assign tbase_o       = tbase;
    assign nmi_active_o  = nmi_active;

endmodule

// File: rtl/trap_ctrl_checker.sv
// Module: trap_ctrl_checker
// Port-level properties of trap_ctrl, attached by bind.
// Assumes inputs are known from the first clock edge.
module trap_ctrl_checker #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [XLEN-1:0]   boot_addr_i,
    input logic              trap_req_i,
    input logic              trap_irq_i,
    input logic [CODE_W-1:0] trap_code_i,
    input logic [XLEN-1:0]   trap_pc_i,
    input logic              ret_req_i,
    input logic              base_we_i,
    input logic [XLEN-1:0]   base_wdata_i,
    input logic              fetch_valid_o,
    input logic [XLEN-1:0]   fetch_pc_o,
    input logic [1:0]        priv_o,
    input logic              ie_o,
    input logic              pie_o,
    input logic [1:0]        ppriv_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [XLEN-1:0]   cause_o,
    input logic [XLEN-1:0]   tbase_o,
    input logic              nmi_active_o
);
    logic accepted;
    assign accepted = trap_req_i && !(trap_irq_i && nmi_active_o);

    assert_entry_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accepted |=> (priv_o == 2'b11) && !ie_o && (epc_o == $past(trap_pc_i))
                     && (pie_o == $past(ie_o)) && (ppriv_o == $past(priv_o)));

    assert_exc_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accepted && !trap_irq_i && !base_we_i) |=> (fetch_pc_o == tbase_o));

    assert_plain_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_req_i && !trap_req_i && !nmi_active_o) |=>
            pie_o && (ppriv_o == 2'b00) && (fetch_pc_o == $past(epc_o))
            && (ie_o == $past(pie_o)) && (priv_o == $past(ppriv_o)));

    assert_base_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_we_i |=> (tbase_o[XLEN-1:8] == $past(base_wdata_i[XLEN-1:8])) && (tbase_o[7:0] == 8'h00));

    assert_nmi_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accepted && trap_irq_i && (trap_code_i == {CODE_W{1'b1}})) |=> nmi_active_o);

    assert_nmi_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_req_i && trap_irq_i && nmi_active_o && !ret_req_i) |=>
            !fetch_valid_o && $stable(epc_o) && $stable(cause_o) && $stable(priv_o));

    assert_one_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accepted || ret_req_i) |=> fetch_valid_o);

    assert_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(accepted || ret_req_i) |=> !fetch_valid_o);

endmodule

bind trap_ctrl trap_ctrl_checker #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W)
) i_trap_ctrl_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .boot_addr_i  (boot_addr_i),
    .trap_req_i   (trap_req_i),
    .trap_irq_i   (trap_irq_i),
    .trap_code_i  (trap_code_i),
    .trap_pc_i    (trap_pc_i),
    .ret_req_i    (ret_req_i),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .fetch_valid_o(fetch_valid_o),
    .fetch_pc_o   (fetch_pc_o),
    .priv_o       (priv_o),
    .ie_o         (ie_o),
    .pie_o        (pie_o),
    .ppriv_o      (ppriv_o),
    .epc_o        (epc_o),
    .cause_o      (cause_o),
    .tbase_o      (tbase_o),
    .nmi_active_o (nmi_active_o)
);

// File: tb/test_trap_ctrl.sv
// Scoreboard bench: tasks queue expected redirects, a monitor compares them.
module test_trap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] boot_addr = 32'h2000_0000;
    logic        trap_req = 1'b0, trap_irq = 1'b0, ret_req = 1'b0, base_we = 1'b0;
    logic [4:0]  trap_code = '0;
    logic [31:0] trap_pc = '0, base_wdata = '0;
    logic        fetch_valid, ie, pie, nmi_active;
    logic [31:0] fetch_pc, epc, cause, tbase;
    logic [1:0]  priv, ppriv;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    trap_ctrl i_trap_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .boot_addr_i(boot_addr),
        .trap_req_i(trap_req), .trap_irq_i(trap_irq), .trap_code_i(trap_code),
        .trap_pc_i(trap_pc), .ret_req_i(ret_req), .base_we_i(base_we),
        .base_wdata_i(base_wdata), .fetch_valid_o(fetch_valid), .fetch_pc_o(fetch_pc),
        .priv_o(priv), .ie_o(ie), .pie_o(pie), .ppriv_o(ppriv), .epc_o(epc),
        .cause_o(cause), .tbase_o(tbase), .nmi_active_o(nmi_active)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: every redirect pulse must match the next queued address.
    always @(negedge clk) begin
        if (rst_n && fetch_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R11: got unexpected redirect %h expected none", fetch_pc);
            end else begin
                check("R11 redirect", fetch_pc, exp_q.pop_front());
            end
        end
    end

    // Drive one request cycle, then wait to the next negedge.
    task automatic issue(input logic t, input logic irq, input logic [4:0] code,
                         input logic [31:0] pc, input logic r);
        @(posedge clk); #1;
        trap_req = t; trap_irq = irq; trap_code = code; trap_pc = pc; ret_req = r;
        @(posedge clk); #1;
        trap_req = 0; trap_irq = 0; trap_code = 0; trap_pc = 0; ret_req = 0;
        @(negedge clk);
    endtask

    task automatic check_status(input string req, input logic [1:0] p, input logic e,
                                input logic pe, input logic [1:0] pp);
        check(req, {priv, ie, pie, ppriv}, {p, e, pe, pp});
    endtask

    initial begin : watchdog
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_status("R1 status", 2'b11, 1'b0, 1'b0, 2'b11);
        check("R1 tbase", tbase, 32'h2000_0000);
        check("R1 nmi", {31'd0, nmi_active}, 32'd0);
        // R2 boot redirect
        exp_q.push_back(32'h2000_0080);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check("R2 boot valid", {31'd0, fetch_valid}, 32'd1);
        @(negedge clk);
        check("R2 valid drops", {31'd0, fetch_valid}, 32'd0);

        // R3/R4 exception code 2 from machine mode
        exp_q.push_back(32'h2000_0000);
        issue(1, 0, 5'd2, 32'h0000_0100, 0);
        check("R3 epc", epc, 32'h0000_0100);
        check("R3 cause", cause, 32'h0000_0002);
        check_status("R3 status", 2'b11, 1'b0, 1'b0, 2'b11);

        // R6 two returns: enable comes up, privilege drops to user
        exp_q.push_back(32'h0000_0100);
        issue(0, 0, 0, 0, 1);
        check_status("R6 first return", 2'b11, 1'b0, 1'b1, 2'b00);
        exp_q.push_back(32'h0000_0100);
        issue(0, 0, 0, 0, 1);
        check_status("R6 second return", 2'b00, 1'b1, 1'b1, 2'b00);

        // R5 timer-style interrupt ID 7 from user mode
        exp_q.push_back(32'h2000_001C);
        issue(1, 1, 5'd7, 32'h0000_0200, 0);
        check("R5 cause", cause, 32'h8000_0007);
        check_status("R3 irq status", 2'b11, 1'b0, 1'b1, 2'b00);

        // R8 non-maskable interrupt inside the handler
        exp_q.push_back(32'h2000_007C);
        issue(1, 1, 5'd31, 32'h0000_0300, 0);
        check("R8 nmi flag", {31'd0, nmi_active}, 32'd1);
        check("R8 epc", epc, 32'h0000_0300);
        check("R8 cause", cause, 32'h8000_001F);
        check_status("R8 status", 2'b11, 1'b0, 1'b0, 2'b11);

        // R9 interrupts ignored while the non-maskable handler runs
        issue(1, 1, 5'd11, 32'h0000_0444, 0);
        check("R9 no redirect", {31'd0, fetch_valid}, 32'd0);
        check("R9 epc kept", epc, 32'h0000_0300);
        check("R9 cause kept", cause, 32'h8000_001F);
        issue(1, 1, 5'd31, 32'h0000_0448, 0);
        check("R9 nmi ignored", epc, 32'h0000_0300);

        // R10 return from non-maskable handler restores backup
        exp_q.push_back(32'h0000_0300);
        issue(0, 0, 0, 0, 1);
        check("R10 nmi cleared", {31'd0, nmi_active}, 32'd0);
        check("R10 epc", epc, 32'h0000_0200);
        check("R10 cause", cause, 32'h8000_0007);
        check_status("R10 status", 2'b11, 1'b0, 1'b1, 2'b00);
        exp_q.push_back(32'h0000_0200);
        issue(0, 0, 0, 0, 1);
        check_status("R10 outer return", 2'b00, 1'b1, 1'b1, 2'b00);

        // R7 trap-base write with nonzero low byte
        @(posedge clk); #1; base_we = 1; base_wdata = 32'h4000_12FF;
        @(posedge clk); #1; base_we = 0; base_wdata = 0;
        @(negedge clk);
        check("R7 tbase", tbase, 32'h4000_1200);

        // R4 user ecall (code 8) goes to new base
        exp_q.push_back(32'h4000_1200);
        issue(1, 0, 5'd8, 32'h0000_0400, 0);
        check("R4 cause", cause, 32'h0000_0008);
        check_status("R4 status", 2'b11, 1'b0, 1'b1, 2'b00);

        // R11 trap and return together: trap wins, fast ID 16
        exp_q.push_back(32'h4000_1240);
        issue(1, 1, 5'd16, 32'h0000_0500, 1);
        check("R11 epc", epc, 32'h0000_0500);
        check("R11 cause", cause, 32'h8000_0010);
        check_status("R11 status", 2'b11, 1'b0, 1'b0, 2'b11);

        repeat (3) @(negedge clk);
        check("R11 queue drained", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule